// File: doc/BRIEF.md
# HDB3/B3ZS Zero-Substitution Line Encoder

This block turns a serial NRZ transmit bit stream into bipolar line data on two rails, one carrying positive pulses and one carrying negative pulses. Each one bit becomes a mark whose polarity alternates from the previous mark (AMI). Long zero runs are replaced by code words that contain a deliberate bipolar violation. In HDB3 mode the replaced run is four zeros long. In B3ZS mode it is three zeros long.

Each substitution ends in a violation pulse V, which has the same polarity as the pulse just before it. The substitution may also start with a balancing pulse B. B is inserted when an even number of pulses has gone out since the last violation, so that an odd number of pulses always separates successive violations. Every bit passes through a four-stage symbol pipeline, which gives the encoder room to put a B pulse in front of a zero run it has only just recognised. The latency is the same in both modes.

Two disable inputs turn substitution off: a per-channel one and a shared one. The shared one wins whenever it is high. With substitution off, the block sends plain AMI and keeps its polarity and parity state.

Top module: `hdb3_b3zs_encoder`

## Requirements
- R1: While reset is low, both rails are low. After release they stay low until the first sampled bit reaches the output, because the empty pipeline produces no pulses.
- R2: A bit sampled on rising edge k appears on the rails right after rising edge k+4, in both modes. Ordinary ones alternate in polarity. After reset the previous pulse counts as negative, so the first mark is positive (pos_out high).
- R3: With b3zs_sel = 0 and substitution enabled, every run of four zeros counted since the last mark or substitution is sent as 000V or B00V.
- R4: With b3zs_sel = 1 and substitution enabled, every run of three zeros counted since the last mark or substitution is sent as 00V or B0V.
- R5: A code word starts with B when the number of pulses since the last violation is even, and with a plain zero when it is odd. The count restarts at zero after each V. After reset the count is even.
- R6: A V pulse has the polarity of the pulse sent just before it. A B pulse has the opposite polarity.
- R7: pos_out and neg_out are never high in the same cycle.
- R8: When chan_dis is high as a zero is sampled, that zero cannot complete a substitution and goes out as no pulse. Marks keep AMI alternation.
- R9: all_dis high disables substitution whatever the value of chan_dis.
- R10: The polarity and parity state keeps running while substitution is off. Changing the disable inputs or the mode therefore never sends two same-polarity marks in a row, except where a V pulse is intended. Mode and disable are sampled together with the data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| nrz_in | input | 1 | Serial NRZ data bit |
| b3zs_sel | input | 1 | 0 selects HDB3 (four-zero runs), 1 selects B3ZS (three-zero runs) |
| chan_dis | input | 1 | Per-channel substitution disable |
| all_dis | input | 1 | Shared disable that overrides chan_dis |
| pos_out | output | 1 | Positive-pulse rail |
| neg_out | output | 1 | Negative-pulse rail |

## Verification
The hardest situation to reach from the ports is a zero run that began while substitution was off, or under the other mode, and is completed only after the setting changes. To reach it, the bench switches the disable inputs and the mode at cycle intervals that are prime and unrelated to each other, over a zero-heavy pseudo-random stream. It also sweeps every 8-bit pattern back to back in each fixed mode, so that runs of every length straddle both parities. An independent stream model in the bench predicts each rail value.

// File: rtl/hdb3_b3zs_encoder.sv
module hdb3_b3zs_encoder #(
  parameter int STAGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nrz_in,
  input  logic b3zs_sel,
  input  logic chan_dis,
  input  logic all_dis,
  output logic pos_out,
  output logic neg_out
);
  localparam int LAST = STAGES - 1;

  typedef enum logic [2:0] {S_IDLE, S_ZERO, S_ONE, S_HEAD, S_VIOL} sym_t;

  sym_t st [STAGES];
  logic last_pol;
  logic par;

  wire dis  = chan_dis | all_dis;
  wire hit4 = !dis && !b3zs_sel && !nrz_in &&
              st[0] == S_ZERO && st[1] == S_ZERO && st[2] == S_ZERO;
  wire hit3 = !dis && b3zs_sel && !nrz_in &&
              st[0] == S_ZERO && st[1] == S_ZERO;

  wire is_viol = st[LAST] == S_VIOL;
  wire mark    = st[LAST] == S_ONE || is_viol || (st[LAST] == S_HEAD && !par);
  wire pol     = is_viol ? last_pol : !last_pol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= S_IDLE;
      pos_out  <= 1'b0;
      neg_out  <= 1'b0;
      last_pol <= 1'b0;
      par      <= 1'b0;
    end else begin
      st[0] <= (hit3 || hit4) ? S_VIOL : (nrz_in ? S_ONE : S_ZERO);
      st[1] <= st[0];
      st[2] <= hit3 ? S_HEAD : st[1];
      st[3] <= hit4 ? S_HEAD : st[2];
      pos_out <= mark && pol;
      neg_out <= mark && !pol;
      if (mark) last_pol <= pol;
      if (is_viol) par <= 1'b0;
      else if (mark) par <= !par;
    end
  end

  a_r7_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos_out && neg_out));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st[LAST] == S_IDLE) |=> (!pos_out && !neg_out));

  a_r5_odd_head_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st[LAST] == S_HEAD && par) |=> (!pos_out && !neg_out));

  a_r6_viol_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (st[LAST] == S_VIOL) |=> (pos_out == $past(last_pol) && neg_out == !$past(last_pol)));

  a_r3_head_precedes_viol: assert property (@(posedge clk) disable iff (!rst_n)
    (st[0] == S_VIOL) |-> (st[2] == S_HEAD || st[3] == S_HEAD));

  a_r8_no_sub_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_dis || all_dis) |=> (st[0] != S_VIOL));
endmodule

// File: tb/tb_hdb3_b3zs_encoder.sv
module tb_hdb3_b3zs_encoder;
  localparam int MAXL = 2200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nrz_in = 1'b0, b3zs_sel = 1'b0, chan_dis = 1'b0, all_dis = 1'b0;
  logic pos_out, neg_out;

  int total = 0;
  int bad = 0;

  bit d_bit [MAXL];
  bit d_mode [MAXL];
  bit d_cd [MAXL];
  bit d_ad [MAXL];
  bit e_pos [MAXL];
  bit e_neg [MAXL];

  always #10 clk = !clk;

  hdb3_b3zs_encoder dut (
    .clk(clk), .rst_n(rst_n), .nrz_in(nrz_in), .b3zs_sel(b3zs_sel),
    .chan_dis(chan_dis), .all_dis(all_dis), .pos_out(pos_out), .neg_out(neg_out)
  );

  task automatic model(input int len);
    bit last = 1'b0;
    bit par = 1'b0;
    int zc = 0;
    for (int i = 0; i < len; i++) begin
      e_pos[i] = 1'b0;
      e_neg[i] = 1'b0;
      if (d_bit[i]) begin
        last = !last;
        e_pos[i] = last;
        e_neg[i] = !last;
        par = !par;
        zc = 0;
      end else begin
        int n;
        zc++;
        n = d_mode[i] ? 3 : 4;
        if (!(d_cd[i] || d_ad[i]) && zc >= n) begin
          if (!par) begin
            last = !last;
            e_pos[i-n+1] = last;
            e_neg[i-n+1] = !last;
          end
          e_pos[i] = last;
          e_neg[i] = !last;
          par = 1'b0;
          zc = 0;
        end
      end
    end
  endtask

  task automatic run(input int len, input string tag);
    model(len);
    rst_n = 1'b0;
    nrz_in = 1'b0;
    repeat (3) @(negedge clk);
    total++;
    if (pos_out || neg_out) begin
      bad++;
      $display("FAIL R1 rails in reset pos=%0b neg=%0b expected 0 0", pos_out, neg_out);
    end
    rst_n = 1'b1;
    for (int c = 0; c < len; c++) begin
      if (c > 0) @(negedge clk);
      total++;
      if (pos_out && neg_out) begin
        bad++;
        $display("FAIL R7 both rails high at step %0d", c);
      end
      if (c < 5) begin
        total++;
        if (pos_out || neg_out) begin
          bad++;
          $display("FAIL R1 step %0d pos=%0b neg=%0b expected 0 0", c, pos_out, neg_out);
        end
      end else begin
        total++;
        if (pos_out !== e_pos[c-5] || neg_out !== e_neg[c-5]) begin
          bad++;
          $display("FAIL %s/R2 bit %0d pos=%0b neg=%0b expected %0b %0b",
                   tag, c-5, pos_out, neg_out, e_pos[c-5], e_neg[c-5]);
        end
      end
      nrz_in = d_bit[c];
      b3zs_sel = d_mode[c];
      chan_dis = d_cd[c];
      all_dis = d_ad[c];
    end
  endtask

  task automatic fill_sweep(input bit mode);
    for (int p = 0; p < 256; p++)
      for (int b = 0; b < 8; b++) begin
        d_bit[p*8+b] = p[7-b];
        d_mode[p*8+b] = mode;
        d_cd[p*8+b] = 1'b0;
        d_ad[p*8+b] = 1'b0;
      end
    for (int i = 2048; i < MAXL; i++) begin
      d_bit[i] = 1'b0; d_mode[i] = mode; d_cd[i] = 1'b0; d_ad[i] = 1'b0;
    end
  endtask

  task automatic fill_mixed(input bit use_all, input logic [15:0] seed);
    logic [15:0] lf = seed;
    for (int i = 0; i < MAXL; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      d_bit[i] = (lf[2:0] == 3'd0);
      d_mode[i] = ((i / 101) % 2) == 1;
      if (use_all) begin
        d_ad[i] = ((i / 37) % 3) == 1;
        d_cd[i] = lf[9];
      end else begin
        d_ad[i] = 1'b0;
        d_cd[i] = ((i / 37) % 2) == 1;
      end
    end
  endtask

  initial begin
    fill_sweep(1'b0);
    run(2100, "R3/R5/R6");
    fill_sweep(1'b1);
    run(2100, "R4/R5/R6");
    fill_mixed(1'b0, 16'hACE1);
    run(2100, "R8/R10");
    fill_mixed(1'b1, 16'h1D2B);
    run(2100, "R9/R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule